// File: doc/BRIEF.md
# Vector Octet Right-Shift Execution Unit

This unit is one execution slice beside a 128-bit SIMD register file. Each cycle it may accept one 32-bit instruction word together with an issue strobe. It decodes the word in one of two encodings. The short form addresses 32 vector registers. The wide form addresses 128 vector registers and assembles its 7-bit register numbers from fields spread across the word.

The unit sends two read indices to the register file and receives two 128-bit operands back in the same cycle. The first operand is moved toward its least significant byte by a whole number of bytes, from 0 to 15. That count is a 4-bit field inside the lowest byte of the second operand. Zeros fill the vacated most significant bytes. Bytes are numbered big-endian, so byte 0 is bits 127:120 and byte 15 is bits 7:0.

The result is presented on a registered write port one clock after issue. An operand read in the following cycle picks up that pending result through a forwarding path. Words that match neither encoding raise an illegal-instruction flag and produce no write.

Top module: `vos_unit`

## Requirements
- R1: For a legal issue with count N, the written value equals operand A shifted right by 8·N bits, with zeros in the top 8·N bits.
- R2: N is bits 6 down to 3 of operand B (the count field inside byte 15, B[7:0]). All other bits of B, including B[7], B[2:0] and bytes 0–14, have no effect on the result.
- R3: When N is 0, the written value equals operand A unchanged.
- R4: A word with (instr & 0xFC0007FF) == 0x1000044C is the short form. Its destination is instr[25:21], source A is instr[20:16] and source B is instr[15:11], each zero-extended to 7 bits. The two read indices appear on the read-index outputs in the issue cycle.
- R5: A word with (instr & 0xFC0003D0) == 0x140003D0 is the wide form. Its destination is {instr[3:2], instr[25:21]}. Source A is {instr[10], instr[5], instr[20:16]}. Source B is {instr[1:0], instr[15:11]}.
- R6: A legal issue in cycle t drives wr_en_o high in cycle t+1 only, with the destination on wr_idx_o and the result on wr_data_o.
- R7: A valid issue whose word matches neither form raises illegal_o in cycle t+1 and keeps wr_en_o low.
- R8: When an operand index read in cycle t+1 equals the destination being written in that cycle, the unit uses the new result instead of the register file value.
- R9: Cycles without issue_valid_i are followed by wr_en_o and illegal_o low.
- R10: While and right after reset, wr_en_o and illegal_o are low.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| rd_a_idx_o | output | 7 | Register file read index for operand A |
| rd_a_data_i | input | 128 | Register file data for operand A |
| rd_b_idx_o | output | 7 | Register file read index for operand B |
| rd_b_data_i | input | 128 | Register file data for operand B |
| wr_en_o | output | 1 | Register file write enable |
| wr_idx_o | output | 7 | Register file write index |
| wr_data_o | output | 128 | Register file write data |
| illegal_o | output | 1 | Issued word was not a recognised encoding |

## Verification
The assertions assume that the register file answers a read index with its data in the same cycle, and that the file commits wr_data_o at the clock edge that ends the write cycle. The result and forwarding checks depend on that timing. They also assume that issue_valid_i and instr_i are stable across each clock edge. The bench meets these assumptions with a register file model that reads asynchronously and writes on the clock. That model also carries a separate preload port, which is used only in cycles when the unit is not writing. All stimulus is driven on the falling edge.

// File: rtl/vos_pkg.sv
package vos_pkg;
  localparam int unsigned VEC_W_DEF  = 128;
  localparam int unsigned IDX_W_DEF  = 7;
  localparam int unsigned INSTR_W    = 32;

  localparam logic [31:0] SHORT_MASK = 32'hFC00_07FF;
  localparam logic [31:0] SHORT_PAT  = 32'h1000_044C;
  localparam logic [31:0] WIDE_MASK  = 32'hFC00_03D0;
  localparam logic [31:0] WIDE_PAT   = 32'h1400_03D0;

  typedef enum logic [1:0] {
    FORM_NONE  = 2'b00,
    FORM_SHORT = 2'b01,
    FORM_WIDE  = 2'b10
  } form_e;

  typedef struct packed {
    form_e      form;
    logic [6:0] dst;
    logic [6:0] src_a;
    logic [6:0] src_b;
  } dec_t;

  function automatic logic match_short(input logic [31:0] w);
    return (w & SHORT_MASK) == SHORT_PAT;
  endfunction

  function automatic logic match_wide(input logic [31:0] w);
    return (w & WIDE_MASK) == WIDE_PAT;
  endfunction

  function automatic dec_t decode_word(input logic [31:0] w);
    dec_t d;
    d.form  = FORM_NONE;
    d.dst   = {2'b00, w[25:21]};
    d.src_a = {2'b00, w[20:16]};
    d.src_b = {2'b00, w[15:11]};
    if (match_short(w)) begin
      d.form = FORM_SHORT;
    end else if (match_wide(w)) begin
      d.form  = FORM_WIDE;
      d.dst   = {w[3:2], w[25:21]};
      d.src_a = {w[10], w[5], w[20:16]};
      d.src_b = {w[1:0], w[15:11]};
    end
    return d;
  endfunction
endpackage

// File: rtl/vos_decode.sv
module vos_decode
  import vos_pkg::*;
#(
  parameter int unsigned IDX_W = IDX_W_DEF
) (
  input  logic [31:0]      instr_i,
  output logic             is_short_o,
  output logic             is_wide_o,
  output logic [IDX_W-1:0] dst_o,
  output logic [IDX_W-1:0] src_a_o,
  output logic [IDX_W-1:0] src_b_o
);
  dec_t dec;

  always_comb begin
    dec        = decode_word(instr_i);
    is_short_o = (dec.form == FORM_SHORT);
    is_wide_o  = (dec.form == FORM_WIDE);
    dst_o      = IDX_W'(dec.dst);
    src_a_o    = IDX_W'(dec.src_a);
    src_b_o    = IDX_W'(dec.src_b);
  end
endmodule

// File: rtl/vos_fwd.sv
module vos_fwd #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned IDX_W = 7
) (
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [VEC_W-1:0] rf_data_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [VEC_W-1:0] wr_data_i,
  output logic             hit_o,
  output logic [VEC_W-1:0] data_o
);
  always_comb begin
    hit_o  = wr_en_i && (wr_idx_i == rd_idx_i);
    data_o = hit_o ? wr_data_i : rf_data_i;
  end
endmodule

// File: rtl/vos_byte_shifter.sv
module vos_byte_shifter #(
  parameter int unsigned VEC_W = 128,
  localparam int unsigned NBYTES = VEC_W / 8,
  localparam int unsigned CNT_W  = $clog2(NBYTES)
) (
  input  logic [VEC_W-1:0] data_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [VEC_W-1:0] data_o
);
  logic [VEC_W-1:0] stage [CNT_W+1];

  assign stage[0] = data_i;

  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int unsigned SH = 8 * (1 << k);
    assign stage[k+1] = cnt_i[k] ? (stage[k] >> SH) : stage[k];
  end

  assign data_o = stage[CNT_W];
endmodule

// File: rtl/vos_unit.sv
module vos_unit
  import vos_pkg::*;
#(
  parameter int unsigned VEC_W = VEC_W_DEF,
  parameter int unsigned IDX_W = IDX_W_DEF,
  localparam int unsigned NBYTES  = VEC_W / 8,
  localparam int unsigned CNT_W   = $clog2(NBYTES),
  localparam int unsigned CNT_LSB = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid_i,
  input  logic [31:0]      instr_i,
  output logic [IDX_W-1:0] rd_a_idx_o,
  input  logic [VEC_W-1:0] rd_a_data_i,
  output logic [IDX_W-1:0] rd_b_idx_o,
  input  logic [VEC_W-1:0] rd_b_data_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [VEC_W-1:0] wr_data_o,
  output logic             illegal_o
);
  logic             dec_short;
  logic             dec_wide;
  logic             dec_legal;
  logic [IDX_W-1:0] dec_dst;
  logic [IDX_W-1:0] dec_a;
  logic [IDX_W-1:0] dec_b;
  logic             fwd_hit_a;
  logic             fwd_hit_b;
  logic [VEC_W-1:0] op_a;
  logic [VEC_W-1:0] op_b;
  logic [CNT_W-1:0] shift_cnt;
  logic [VEC_W-1:0] shift_res;
  logic             wr_en_q;
  logic [IDX_W-1:0] wr_idx_q;
  logic [VEC_W-1:0] wr_data_q;
  logic             illegal_q;

  vos_decode #(.IDX_W(IDX_W)) u_dec (
    .instr_i    (instr_i),
    .is_short_o (dec_short),
    .is_wide_o  (dec_wide),
    .dst_o      (dec_dst),
    .src_a_o    (dec_a),
    .src_b_o    (dec_b)
  );

  assign dec_legal  = dec_short || dec_wide;
  assign rd_a_idx_o = dec_a;
  assign rd_b_idx_o = dec_b;

  vos_fwd #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_fwd_a (
    .rd_idx_i  (dec_a),
    .rf_data_i (rd_a_data_i),
    .wr_en_i   (wr_en_q),
    .wr_idx_i  (wr_idx_q),
    .wr_data_i (wr_data_q),
    .hit_o     (fwd_hit_a),
    .data_o    (op_a)
  );

  vos_fwd #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_fwd_b (
    .rd_idx_i  (dec_b),
    .rf_data_i (rd_b_data_i),
    .wr_en_i   (wr_en_q),
    .wr_idx_i  (wr_idx_q),
    .wr_data_i (wr_data_q),
    .hit_o     (fwd_hit_b),
    .data_o    (op_b)
  );

  // Count field: bits 6..3 of the least significant byte of operand B.
  assign shift_cnt = op_b[CNT_LSB +: CNT_W];

  vos_byte_shifter #(.VEC_W(VEC_W)) u_shift (
    .data_i (op_a),
    .cnt_i  (shift_cnt),
    .data_o (shift_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
      illegal_q <= 1'b0;
    end else begin
      wr_en_q   <= issue_valid_i && dec_legal;
      illegal_q <= issue_valid_i && !dec_legal;
      if (issue_valid_i && dec_legal) begin
        wr_idx_q  <= dec_dst;
        wr_data_q <= shift_res;
      end
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/vos_unit_chk.sv
module vos_unit_chk #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned IDX_W = 7,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_valid_i,
  input logic             dec_short,
  input logic             dec_wide,
  input logic [IDX_W-1:0] dec_dst,
  input logic [VEC_W-1:0] op_a,
  input logic [CNT_W-1:0] shift_cnt,
  input logic             wr_en_o,
  input logic [IDX_W-1:0] wr_idx_o,
  input logic [VEC_W-1:0] wr_data_o,
  input logic             illegal_o
);
  AST_ONE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec_short, dec_wide})); // R5

  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_i && (dec_short || dec_wide) |=>
      ((wr_data_o >> (VEC_W - 8 * int'($past(shift_cnt)))) == '0)); // R1

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_i && (dec_short || dec_wide) && (shift_cnt == '0) |=>
      (wr_data_o == $past(op_a))); // R3

  AST_WRITE_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_i && (dec_short || dec_wide) |=>
      (wr_en_o && wr_idx_o == $past(dec_dst))); // R6

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !wr_en_o); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid_i |=> (!wr_en_o && !illegal_o)); // R9
endmodule

bind vos_unit vos_unit_chk #(
  .VEC_W (VEC_W),
  .IDX_W (IDX_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .issue_valid_i (issue_valid_i),
  .dec_short     (dec_short),
  .dec_wide      (dec_wide),
  .dec_dst       (dec_dst),
  .op_a          (op_a),
  .shift_cnt     (shift_cnt),
  .wr_en_o       (wr_en_o),
  .wr_idx_o      (wr_idx_o),
  .wr_data_o     (wr_data_o),
  .illegal_o     (illegal_o)
);

// File: tb/vos_unit_tb.sv
module vos_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         issue_valid_i = 1'b0;
  logic [31:0]  instr_i = '0;
  logic [6:0]   rd_a_idx_o, rd_b_idx_o, wr_idx_o;
  logic [127:0] rd_a_data_i, rd_b_data_i, wr_data_o;
  logic         wr_en_o, illegal_o;

  logic         ld_en = 1'b0;
  logic [6:0]   ld_idx = '0;
  logic [127:0] ld_data = '0;
  logic [127:0] rf [128];

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  vos_unit u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_valid_i (issue_valid_i),
    .instr_i       (instr_i),
    .rd_a_idx_o    (rd_a_idx_o),
    .rd_a_data_i   (rd_a_data_i),
    .rd_b_idx_o    (rd_b_idx_o),
    .rd_b_data_i   (rd_b_data_i),
    .wr_en_o       (wr_en_o),
    .wr_idx_o      (wr_idx_o),
    .wr_data_o     (wr_data_o),
    .illegal_o     (illegal_o)
  );

  // Register file model: asynchronous read, write on the clock.
  assign rd_a_data_i = rf[rd_a_idx_o];
  assign rd_b_data_i = rf[rd_b_idx_o];

  always_ff @(posedge clk) begin
    if (wr_en_o) rf[wr_idx_o] <= wr_data_o;
    else if (ld_en) rf[ld_idx] <= ld_data;
  end

  function automatic logic [127:0] ref_shift(input logic [127:0] a, input logic [127:0] b);
    int n;
    n = int'(b[7:0]) / 8 % 16;
    return a >> (n * 8);
  endfunction

  function automatic logic [31:0] w_short(input int d, input int a, input int b);
    return 32'h1000_044C | (32'(d) << 21) | (32'(a) << 16) | (32'(b) << 11);
  endfunction

  function automatic logic [31:0] w_wide(input logic [6:0] d, input logic [6:0] a, input logic [6:0] b);
    logic [31:0] w;
    w = 32'h1400_03D0;
    w[25:21] = d[4:0];
    w[20:16] = a[4:0];
    w[15:11] = b[4:0];
    w[10]    = a[6];
    w[5]     = a[5];
    w[3:2]   = d[6:5];
    w[1:0]   = b[6:5];
    return w;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [6:0] idx, input logic [127:0] val);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = idx; ld_data = val;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // Issue one word; check the write one cycle later.
  task automatic run_one(input string req, input logic [31:0] w, input logic [6:0] d,
                         input logic [6:0] a, input logic [6:0] b);
    logic [127:0] exp;
    exp = ref_shift(rf[a], rf[b]);
    @(negedge clk);
    issue_valid_i = 1'b1; instr_i = w;
    #1;
    chk({req, " read idx A"}, 128'(rd_a_idx_o), 128'(a));
    chk({req, " read idx B"}, 128'(rd_b_idx_o), 128'(b));
    @(negedge clk);
    issue_valid_i = 1'b0;
    chk({req, " wr_en"}, 128'(wr_en_o), 128'd1);
    chk({req, " wr_idx"}, 128'(wr_idx_o), 128'(d));
    chk({req, " data"}, wr_data_o, exp);
  endtask

  task automatic t_reset;
    chk("R10 wr_en in reset", 128'(wr_en_o), 128'd0);
    chk("R10 illegal in reset", 128'(illegal_o), 128'd0);
  endtask

  task automatic t_counts;
    load(7'd1, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF);
    for (int n = 0; n < 16; n++) begin
      load(7'd2, {120'h0, 1'b0, 4'(n), 3'b000});
      run_one(n == 0 ? "R3 count0" : (n == 15 ? "R1 count15" : "R1 count"),
              w_short(3, 1, 2), 7'd3, 7'd1, 7'd2);
    end
  endtask

  task automatic t_stray;
    load(7'd4, 128'hFEDC_BA98_7654_3210_0F1E_2D3C_4B5A_6978);
    load(7'd5, {120'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FF, 8'b1_0101_111});
    run_one("R2 stray bits count5", w_short(6, 4, 5), 7'd6, 7'd4, 7'd5);
    load(7'd5, {120'hA5A5_A5A5_A5A5_A5A5_A5A5_A5A5_A5A5_A5, 8'b1_0000_111});
    run_one("R2 stray bits count0", w_short(6, 4, 5), 7'd6, 7'd4, 7'd5);
  endtask

  task automatic t_short_fields;
    load(7'd31, 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555);
    load(7'd0,  {120'h0, 8'd9 << 3});
    run_one("R4 short 31,31,0", w_short(31, 31, 0), 7'd31, 7'd31, 7'd0);
  endtask

  task automatic t_wide_fields;
    load(7'd32,  128'h1234_5678_9ABC_DEF0_1357_9BDF_2468_ACE0);
    load(7'd127, {120'h0, 8'd3 << 3});
    load(7'd0,   {120'h0, 8'd12 << 3});
    run_one("R5 wide d127 a32 b0", w_wide(7'd127, 7'd32, 7'd0), 7'd127, 7'd32, 7'd0);
    run_one("R5 wide d0 a127 b32", w_wide(7'd0, 7'd127, 7'd32), 7'd0, 7'd127, 7'd32);
    run_one("R5 wide d32 a0 b127", w_wide(7'd32, 7'd0, 7'd127), 7'd32, 7'd0, 7'd127);
    run_one("R5 wide d31 a96 b64", w_wide(7'd31, 7'd96, 7'd64), 7'd31, 7'd96, 7'd64);
  endtask

  task automatic bad_word(input string req, input logic [31:0] w);
    @(negedge clk);
    issue_valid_i = 1'b1; instr_i = w;
    @(negedge clk);
    issue_valid_i = 1'b0;
    chk({req, " illegal"}, 128'(illegal_o), 128'd1);
    chk({req, " no write"}, 128'(wr_en_o), 128'd0);
  endtask

  task automatic t_illegal;
    bad_word("R7 reserved bit wide", w_wide(7'd5, 7'd6, 7'd7) & ~32'h0000_0200);
    bad_word("R7 ext opcode short",  w_short(1, 2, 3) ^ 32'h0000_0001);
    bad_word("R7 primary opcode 6",  32'h1800_044C);
  endtask

  task automatic t_idle;
    instr_i = w_short(3, 1, 2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 idle wr_en", 128'(wr_en_o), 128'd0);
      chk("R9 idle illegal", 128'(illegal_o), 128'd0);
    end
  endtask

  task automatic t_bypass;
    logic [127:0] a, e1, e2, e3;
    a = 128'h8877_6655_4433_2211_FFEE_DDCC_BBAA_9988;
    load(7'd10, a);
    load(7'd11, {120'h0, 8'd2 << 3});
    load(7'd12, {120'h0, 8'd1 << 3});
    load(7'd13, 128'h0);
    e1 = a >> 16;
    e2 = e1 >> 8;
    e3 = e2 >> (8 * ((e2[7:0] >> 3) & 8'hF));
    @(negedge clk);
    issue_valid_i = 1'b1; instr_i = w_short(13, 10, 11);
    @(negedge clk);
    instr_i = w_short(14, 13, 12);
    chk("R6 first write", wr_data_o, e1);
    @(negedge clk);
    instr_i = w_short(15, 14, 14);
    chk("R8 forward to A", wr_data_o, e2);
    @(negedge clk);
    issue_valid_i = 1'b0;
    chk("R8 forward to A and B", wr_data_o, e3);
    @(negedge clk);
    chk("R6 single pulse", 128'(wr_en_o), 128'd0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) rf[i] = 128'(i) * 128'h0101_0101;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_counts();
    t_stray();
    t_short_fields();
    t_wide_fields();
    t_illegal();
    t_idle();
    t_bypass();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule